// File: doc/BRIEF.md
# 100BASE-TX Receive Carrier Sense and Stream Framer

This block sits after symbol alignment and descrambling in a 100 Mb/s receive path. It takes one 5-bit code group per valid strobe and produces the MII-style receive signals: carrier sense, receive data valid, receive error and a decoded 4-bit nibble. A stream opens only on a start delimiter of a /J/ code group followed directly by a /K/ code group. Both delimiter slots are reported as preamble nibbles. Data code groups are decoded through the 4B/5B table. The stream closes on an end delimiter of a /T/ code group followed directly by an /R/ code group, or early on an idle code group.

The delimiters are two symbols long, so the block holds one code group back and decides each slot with one symbol of lookahead. Its outputs therefore describe the previous valid code group and are registered. Carrier ends in one of two ways. A proper end delimiter ends it quietly. An idle that arrives with no end delimiter ends it with a single-clock receive-error pulse. A lone /J/ is rejected as false carrier. A low link status clears all outputs and puts the block back to hunting for idle.

Top module: `rx_carrier_framer`

## Requirements
- R1: Outputs are registered. Each valid symbol (sym_vld_i=1) updates them on the next clock edge to describe the previous valid symbol. crs_o, rx_dv_o and rxd_o hold between updates. rx_er_o is a strobe that lasts one clock per update. After reset all outputs are 0, the first valid symbol causes no update, and an idle is needed before a stream can open.
- R2: Code groups: J=11000, K=10001, T=01101, R=00111, I=11111. Once an idle has been seen, a J directly followed by K raises crs_o and rx_dv_o. Both the J slot and the K slot output rxd_o=0101.
- R3: Inside a stream each data code group gives crs_o=1, rx_dv_o=1, rx_er_o=0 and its 4B/5B nibble. The mapping for 0..F is 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. rx_dv_o is never high without crs_o.
- R4: In a stream, T directly followed by R ends carrier. The T slot and the R slot both output crs_o=0, rx_dv_o=0, rx_er_o=0 and rxd_o=0000. A J/K straight after the R opens a new stream.
- R5: In a stream, an I with no preceding T/R ends carrier. That slot gives crs_o=0 and rx_dv_o=0, and rx_er_o=1 for exactly one clock.
- R6: In a stream, any code group that is not data, not I and not a T followed by R gives crs_o=1, rx_dv_o=1, rx_er_o=1 and rxd_o=0000. The stream then continues.
- R7: A J not directly followed by K raises no carrier. J/K pairs are then ignored until an idle is received.
- R8: While link_up_i is 0, all outputs are 0 from the next clock. When the link returns, an idle is needed before J/K opens a stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_i | input | 5 | Aligned, descrambled code group |
| sym_vld_i | input | 1 | Code group strobe |
| link_up_i | input | 1 | Link status; low forces outputs inactive |
| crs_o | output | 1 | Carrier sense |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error strobe |
| rxd_o | output | 4 | Decoded nibble |

## Verification
The main sequence opens streams, sends data nibbles and closes the streams in several ways: a proper T/R, a premature idle, a T followed by a data symbol, and a J/K sent straight after an R. These cases separate the lookahead decisions on J and on T. A J followed by data, and J/K pairs sent without a preceding idle, show that false carrier and the idle hunt block the stream. Gaps in the strobe show that the level outputs hold while the error strobe lasts only one clock. A link drop and a reset in mid-stream show that both clear the outputs and restart the idle hunt.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
    localparam int SYM_W = 5;
    localparam int NIB_W = 4;

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [NIB_W-1:0] nib_t;

    localparam sym_t CG_J = 5'b11000;
    localparam sym_t CG_K = 5'b10001;
    localparam sym_t CG_T = 5'b01101;
    localparam sym_t CG_R = 5'b00111;
    localparam sym_t CG_I = 5'b11111;
    localparam nib_t PREAMBLE_NIB = 4'b0101;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_IDLE,
        ST_KSLOT,
        ST_DATA,
        ST_RSLOT
    } frm_state_e;

    typedef struct packed {
        logic crs;
        logic dv;
        logic er;
        nib_t nib;
    } mii_rx_t;

    typedef struct packed {
        logic ok;
        nib_t nib;
    } dec_t;

    function automatic dec_t decode_cg(sym_t s);
        dec_t d;
        d.ok = 1'b1;
        unique case (s)
            5'b11110: d.nib = 4'h0;
            5'b01001: d.nib = 4'h1;
            5'b10100: d.nib = 4'h2;
            5'b10101: d.nib = 4'h3;
            5'b01010: d.nib = 4'h4;
            5'b01011: d.nib = 4'h5;
            5'b01110: d.nib = 4'h6;
            5'b01111: d.nib = 4'h7;
            5'b10010: d.nib = 4'h8;
            5'b10011: d.nib = 4'h9;
            5'b10110: d.nib = 4'hA;
            5'b10111: d.nib = 4'hB;
            5'b11010: d.nib = 4'hC;
            5'b11011: d.nib = 4'hD;
            5'b11100: d.nib = 4'hE;
            5'b11101: d.nib = 4'hF;
            default: begin
                d.ok  = 1'b0;
                d.nib = '0;
            end
        endcase
        return d;
    endfunction
endpackage

// File: rtl/rsf_sym_hold.sv
module rsf_sym_hold
    import rsf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sym_vld_i,
    input  sym_t sym_i,
    output sym_t held_o,
    output logic adv_o
);
    sym_t held_q;
    logic held_v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= '0;
            held_v_q <= 1'b0;
        end else if (sym_vld_i) begin
            held_q   <= sym_i;
            held_v_q <= 1'b1;
        end
    end

    assign held_o = held_q;
    assign adv_o  = sym_vld_i & held_v_q;

    // R1: no advance can happen on the first strobe after reset
    assert_first_strobe_no_adv_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && sym_vld_i) |-> !adv_o);
endmodule

// File: rtl/rsf_frame_fsm.sv
module rsf_frame_fsm
    import rsf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       link_up_i,
    input  logic       adv_i,
    input  sym_t       cur_i,
    input  sym_t       nxt_i,
    output mii_rx_t    slot_o
);
    frm_state_e st_q, st_d;
    mii_rx_t    slot;
    dec_t       dec;

    always_comb begin
        st_d = st_q;
        slot = '0;
        dec  = decode_cg(cur_i);
        unique case (st_q)
            ST_HUNT: begin
                if (cur_i == CG_I) st_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (cur_i == CG_J) begin
                    if (nxt_i == CG_K) begin
                        slot = '{crs: 1'b1, dv: 1'b1, er: 1'b0, nib: PREAMBLE_NIB};
                        st_d = ST_KSLOT;
                    end else begin
                        st_d = ST_HUNT;
                    end
                end else if (cur_i != CG_I) begin
                    st_d = ST_HUNT;
                end
            end
            ST_KSLOT: begin
                slot = '{crs: 1'b1, dv: 1'b1, er: 1'b0, nib: PREAMBLE_NIB};
                st_d = ST_DATA;
            end
            ST_DATA: begin
                if (cur_i == CG_T && nxt_i == CG_R) begin
                    st_d = ST_RSLOT;
                end else if (cur_i == CG_I) begin
                    slot.er = 1'b1;
                    st_d    = ST_IDLE;
                end else begin
                    slot.crs = 1'b1;
                    slot.dv  = 1'b1;
                    slot.er  = ~dec.ok;
                    slot.nib = dec.ok ? dec.nib : '0;
                end
            end
            ST_RSLOT: st_d = ST_IDLE;
            default:  st_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !link_up_i) st_q <= ST_HUNT;
        else if (adv_i)        st_q <= st_d;
    end

    assign slot_o = slot;

    assert_kslot_enters_data_R2: assert property (@(posedge clk) disable iff (rst)
        (adv_i && link_up_i && st_q == ST_KSLOT) |=> (st_q == ST_DATA));

    assert_hunt_waits_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (adv_i && st_q == ST_HUNT && cur_i != CG_I) |=> (st_q == ST_HUNT));
endmodule

// File: rtl/rsf_out_reg.sv
module rsf_out_reg
    import rsf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    link_up_i,
    input  logic    adv_i,
    input  mii_rx_t slot_i,
    output mii_rx_t q_o
);
    mii_rx_t q;

    always_ff @(posedge clk) begin
        if (rst || !link_up_i) q <= '0;
        else if (adv_i)        q <= slot_i;
        else                   q.er <= 1'b0;
    end

    assign q_o = q;

    assert_dv_needs_crs_R3: assert property (@(posedge clk) disable iff (rst)
        q.dv |-> q.crs);

    assert_crs_rise_preamble_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(q.crs) |-> (q.dv && q.nib == PREAMBLE_NIB));

    assert_premature_er_once_R5: assert property (@(posedge clk) disable iff (rst)
        (q.er && !q.crs) |=> !q.er);

    assert_bad_code_flags_R6: assert property (@(posedge clk) disable iff (rst)
        (q.er && q.crs) |-> (q.dv && q.nib == '0));

    assert_link_down_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !link_up_i |=> (q == '0));
endmodule

// File: rtl/rx_carrier_framer.sv
module rx_carrier_framer
    import rsf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SYM_W-1:0] sym_i,
    input  logic             sym_vld_i,
    input  logic             link_up_i,
    output logic             crs_o,
    output logic             rx_dv_o,
    output logic             rx_er_o,
    output logic [NIB_W-1:0] rxd_o
);
    sym_t    held;
    logic    adv;
    mii_rx_t slot;
    mii_rx_t q;

    rsf_sym_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .sym_vld_i (sym_vld_i),
        .sym_i     (sym_i),
        .held_o    (held),
        .adv_o     (adv)
    );

    rsf_frame_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .link_up_i (link_up_i),
        .adv_i     (adv),
        .cur_i     (held),
        .nxt_i     (sym_i),
        .slot_o    (slot)
    );

    rsf_out_reg u_out (
        .clk       (clk),
        .rst       (rst),
        .link_up_i (link_up_i),
        .adv_i     (adv),
        .slot_i    (slot),
        .q_o       (q)
    );

    assign crs_o   = q.crs;
    assign rx_dv_o = q.dv;
    assign rx_er_o = q.er;
    assign rxd_o   = q.nib;
endmodule

// File: tb/rx_carrier_framer_bench.sv
module rx_carrier_framer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] sym_i = 5'b11111;
    logic       sym_vld_i = 1'b0;
    logic       link_up_i = 1'b1;
    logic       crs_o, rx_dv_o, rx_er_o;
    logic [3:0] rxd_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rx_carrier_framer u_rx_carrier_framer (
        .clk(clk), .rst(rst), .sym_i(sym_i), .sym_vld_i(sym_vld_i),
        .link_up_i(link_up_i), .crs_o(crs_o), .rx_dv_o(rx_dv_o),
        .rx_er_o(rx_er_o), .rxd_o(rxd_o)
    );

    localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101,
                           R = 5'b00111, I = 5'b11111;

    typedef struct packed {
        logic [4:0] sym;
        logic       crs;
        logic       dv;
        logic       er;
        logic [3:0] nib;
        logic [3:0] req;
    } vec_t;

    // expected outputs after presenting sym describe the previous symbol
    localparam vec_t VEC [32] = '{
        '{I,        1'b0,1'b0,1'b0,4'h0,4'd1}, // R1 first strobe, no update
        '{I,        1'b0,1'b0,1'b0,4'h0,4'd1},
        '{J,        1'b0,1'b0,1'b0,4'h0,4'd1},
        '{K,        1'b1,1'b1,1'b0,4'h5,4'd2}, // R2 J slot
        '{5'b11011, 1'b1,1'b1,1'b0,4'h5,4'd2}, // R2 K slot
        '{5'b11110, 1'b1,1'b1,1'b0,4'hD,4'd3}, // R3
        '{5'b11101, 1'b1,1'b1,1'b0,4'h0,4'd3},
        '{T,        1'b1,1'b1,1'b0,4'hF,4'd3},
        '{R,        1'b0,1'b0,1'b0,4'h0,4'd4}, // R4 T slot
        '{I,        1'b0,1'b0,1'b0,4'h0,4'd4}, // R4 R slot
        '{J,        1'b0,1'b0,1'b0,4'h0,4'd2},
        '{K,        1'b1,1'b1,1'b0,4'h5,4'd2},
        '{5'b00100, 1'b1,1'b1,1'b0,4'h5,4'd2},
        '{5'b10011, 1'b1,1'b1,1'b1,4'h0,4'd6}, // R6 invalid code
        '{I,        1'b1,1'b1,1'b0,4'h9,4'd6}, // R6 stream continues
        '{I,        1'b0,1'b0,1'b1,4'h0,4'd5}, // R5 premature idle
        '{J,        1'b0,1'b0,1'b0,4'h0,4'd5},
        '{5'b10101, 1'b0,1'b0,1'b0,4'h0,4'd7}, // R7 false carrier
        '{J,        1'b0,1'b0,1'b0,4'h0,4'd7},
        '{K,        1'b0,1'b0,1'b0,4'h0,4'd7}, // R7 J/K ignored in hunt
        '{I,        1'b0,1'b0,1'b0,4'h0,4'd7},
        '{I,        1'b0,1'b0,1'b0,4'h0,4'd7},
        '{J,        1'b0,1'b0,1'b0,4'h0,4'd7},
        '{K,        1'b1,1'b1,1'b0,4'h5,4'd2},
        '{T,        1'b1,1'b1,1'b0,4'h5,4'd2},
        '{5'b01111, 1'b1,1'b1,1'b1,4'h0,4'd6}, // R6 T without R
        '{T,        1'b1,1'b1,1'b0,4'h7,4'd3},
        '{R,        1'b0,1'b0,1'b0,4'h0,4'd4},
        '{J,        1'b0,1'b0,1'b0,4'h0,4'd4},
        '{K,        1'b1,1'b1,1'b0,4'h5,4'd4}, // R4 J/K right after R
        '{I,        1'b1,1'b1,1'b0,4'h5,4'd2},
        '{I,        1'b0,1'b0,1'b1,4'h0,4'd5}  // R5
    };

    task automatic chk(input string tag, input logic c, input logic d,
                       input logic e, input logic [3:0] n);
        n_cmp++;
        if (crs_o !== c || rx_dv_o !== d || rx_er_o !== e || rxd_o !== n) begin
            n_bad++;
            $display("FAIL %s actual crs=%b dv=%b er=%b rxd=%h expected crs=%b dv=%b er=%b rxd=%h",
                     tag, crs_o, rx_dv_o, rx_er_o, rxd_o, c, d, e, n);
        end
    endtask

    task automatic send(input logic [4:0] s);
        sym_i = s;
        sym_vld_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic gap();
        sym_vld_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog R1 actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset", 1'b0, 1'b0, 1'b0, 4'h0);
        rst = 1'b0;

        for (int k = 0; k < 32; k++) begin
            send(VEC[k].sym);
            chk($sformatf("R%0d vec %0d", VEC[k].req, k),
                VEC[k].crs, VEC[k].dv, VEC[k].er, VEC[k].nib);
        end

        // R1: reset in mid-stream, then idle hunt again
        send(J); send(K); send(5'b11011);
        chk("R2 open before reset", 1'b1, 1'b1, 1'b0, 4'h5);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 mid-stream reset", 1'b0, 1'b0, 1'b0, 4'h0);
        rst = 1'b0;
        send(J); chk("R1 first strobe after reset", 1'b0, 1'b0, 1'b0, 4'h0);
        send(K); chk("R1 J/K without idle", 1'b0, 1'b0, 1'b0, 4'h0);
        send(I); send(I); send(J);
        send(K); chk("R2 opens after idle", 1'b1, 1'b1, 1'b0, 4'h5);

        // R1 hold across strobe gaps, R5 one-clock error strobe
        send(5'b11011); chk("R2 K slot", 1'b1, 1'b1, 1'b0, 4'h5);
        gap(); gap();
        chk("R1 hold in gap", 1'b1, 1'b1, 1'b0, 4'h5);
        send(I); chk("R3 data D", 1'b1, 1'b1, 1'b0, 4'hD);
        send(I); chk("R5 premature idle", 1'b0, 1'b0, 1'b1, 4'h0);
        gap(); chk("R5 error lasts one clock", 1'b0, 1'b0, 1'b0, 4'h0);

        // R8 link drop
        send(J); send(K); send(5'b11110);
        chk("R2 before link drop", 1'b1, 1'b1, 1'b0, 4'h5);
        sym_vld_i = 1'b0;
        link_up_i = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R8 link down clears", 1'b0, 1'b0, 1'b0, 4'h0);
        link_up_i = 1'b1;
        send(J); send(K); chk("R8 J/K needs idle after link", 1'b0, 1'b0, 1'b0, 4'h0);
        send(I); send(I); send(J);
        send(K); chk("R8 recovers after idle", 1'b1, 1'b1, 1'b0, 4'h5);

        finish_run();
    end
endmodule